// File: doc/BRIEF.md
# Protection-Aware Page Cacheability Decider

This block answers one question for an address translation cache: may the outcome of a physical-memory-protection check for a given address be reused for every address in the page holding it, or only for this one access? It scans a table of protection entries, each with a mode field and a precomputed inclusive address range. The lowest-index enabled entry that touches the page settles the answer. If that entry covers the page completely, the whole page may be cached. If it covers only part of the page, caching is refused, so that a narrower, higher-priority rule inside the page cannot be skipped by a cached wider rule.

A lookup is launched with a one-cycle strobe. One clock later the block raises a one-cycle result-valid pulse together with the decision flag. Protection disabled, a zero active-rule count, or no enabled entry touching the page all give the full-page answer.

Top module: `pmp_page_cache_chk`

## Requirements
- R1: Synchronous active-high reset clears `res_valid` to 0 on the next clock edge.
- R2: `res_valid` is high exactly in the cycle after a cycle in which `lk_valid` was high, and low otherwise; `res_page` is held stable while no result is being presented.
- R3: The page of a lookup runs from `lk_addr` with its low `PAGE_BITS` bits (12 by default, 4 KiB) cleared, up to that value plus page size minus one.
- R4: When `prot_en` is 0 or `rule_cnt` is 0, `res_page` is 1 (full-page caching), whatever the entries hold.
- R5: An entry whose mode field (bits 4:3 of its configuration byte) is 0 is disabled and has no effect on the result.
- R6: Entries are examined from index 0 upward; only the lowest-index enabled entry touching the page decides, even if a later entry would give a different answer.
- R7: If the deciding entry's start is at or below the page start and its end is at or above the page end, `res_page` is 1.
- R8: If the deciding entry's start or end lies inside the page, `res_page` is 0 (single-access).
- R9: If no enabled entry touches the page, `res_page` is 1, including the case of a nonzero `rule_cnt` with every entry disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | ADDR_W | Lookup address |
| prot_en | input | 1 | Protection implemented |
| rule_cnt | input | CNT_W | Number of active rules |
| ent_cfg | input | N_ENT*8 | Configuration byte per entry, entry i in bits 8i+7:8i |
| ent_lo | input | N_ENT*ADDR_W | Inclusive start per entry |
| ent_hi | input | N_ENT*ADDR_W | Inclusive end per entry |
| res_valid | output | 1 | One-cycle result pulse |
| res_page | output | 1 | 1 = cache whole page, 0 = single access only |

## Verification
Every cycle, assertions check the valid pulse timing after a strobe, the reset clearing, the forced full-page answer when protection is off or the rule count is zero, and that the decision flag holds still between results. The priority among entries, the skipping of disabled entries, the whole-versus-partial overlap distinction and the no-match default rely on specific table contents, so only the bench scenarios, such as the nested narrow-inside-wide rule pair, show them.

// File: rtl/pmp_page_cache_chk.sv
module pmp_page_cache_chk #(
  parameter int ADDR_W    = 32,
  parameter int N_ENT     = 16,
  parameter int PAGE_BITS = 12,
  parameter int CNT_W     = $clog2(N_ENT + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    lk_valid,
  input  logic [ADDR_W-1:0]       lk_addr,
  input  logic                    prot_en,
  input  logic [CNT_W-1:0]        rule_cnt,
  input  logic [N_ENT*8-1:0]      ent_cfg,
  input  logic [N_ENT*ADDR_W-1:0] ent_lo,
  input  logic [N_ENT*ADDR_W-1:0] ent_hi,
  output logic                    res_valid,
  output logic                    res_page
);
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((64'd1 << PAGE_BITS) - 64'd1);

  logic [ADDR_W-1:0] pg_lo, pg_hi;
  logic [N_ENT-1:0]  on, full, part;
  logic              decide;

  assign pg_lo = lk_addr & ~OFS_MASK;
  assign pg_hi = pg_lo | OFS_MASK;

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    logic [ADDR_W-1:0] lo, hi;
    assign lo      = ent_lo[i*ADDR_W +: ADDR_W];
    assign hi      = ent_hi[i*ADDR_W +: ADDR_W];
    assign on[i]   = ent_cfg[i*8+3 +: 2] != 2'b00;
    assign full[i] = lo <= pg_lo && hi >= pg_hi;
    assign part[i] = (lo >= pg_lo && lo <= pg_hi) || (hi >= pg_lo && hi <= pg_hi);
  end

  always_comb begin
    decide = 1'b1;
    if (prot_en && rule_cnt != '0) begin
      for (int i = N_ENT - 1; i >= 0; i--) begin
        if (on[i] && full[i]) decide = 1'b1;
        else if (on[i] && part[i]) decide = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_page  <= 1'b1;
    end else begin
      res_valid <= lk_valid;
      if (lk_valid) res_page <= decide;
    end
  end

  p_reset_clears_r1: assert property (@(posedge clk) rst |=> !res_valid);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);

  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !res_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> $stable(res_page));

  p_off_full_r4: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && (!prot_en || rule_cnt == '0)) |=> res_page);
endmodule

// File: tb/tb_pmp_page_cache_chk.sv
module tb_pmp_page_cache_chk;
  localparam int AW = 32, NE = 16, CW = 5;

  logic clk = 1'b0, rst = 1'b1, lk_valid = 1'b0, prot_en = 1'b1;
  logic [AW-1:0] lk_addr = '0;
  logic [CW-1:0] rule_cnt = '0;
  logic [NE*8-1:0] ent_cfg = '0;
  logic [NE*AW-1:0] ent_lo = '0, ent_hi = '0;
  logic res_valid, res_page;
  int n_chk = 0, n_bad = 0;

  pmp_page_cache_chk dut (.*);

  always #2 clk = ~clk;

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic clear_tab();
    ent_cfg = '0; ent_lo = '0; ent_hi = '0;
  endtask

  task automatic set_ent(int i, logic [1:0] mode, logic [AW-1:0] lo, logic [AW-1:0] hi);
    ent_cfg[i*8 +: 8] = {3'b000, mode, 3'b111};
    ent_lo[i*AW +: AW] = lo;
    ent_hi[i*AW +: AW] = hi;
  endtask

  // strobe one lookup, check pulse and flag one clock later
  task automatic lookup(string req, logic [AW-1:0] a, logic exp);
    @(negedge clk); lk_addr = a; lk_valid = 1'b1;
    @(negedge clk); lk_valid = 1'b0;
    chk({req, " valid"}, res_valid, 1'b1);
    chk(req, res_page, exp);
    @(negedge clk);
    chk({req, " pulse ends (R2)"}, res_valid, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk); chk("R1 reset", res_valid, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_nested();
    clear_tab(); rule_cnt = 2; prot_en = 1'b1;
    set_ent(0, 2'b11, 32'h8000_0008, 32'h8000_000F);
    set_ent(1, 2'b01, 32'h8000_0000, 32'h8000_0FFF);
    lookup("R8 nested narrow entry", 32'h8000_0000, 1'b0);
    lookup("R3 R8 other offset same page", 32'h8000_0FF4, 1'b0);
    lookup("R9 next page untouched", 32'h8000_1000, 1'b1);
  endtask

  task automatic t_disabled();
    clear_tab(); rule_cnt = 2;
    set_ent(0, 2'b00, 32'h8000_0008, 32'h8000_000F);
    set_ent(1, 2'b01, 32'h8000_0000, 32'h8000_0FFF);
    lookup("R5 off entry skipped", 32'h8000_0010, 1'b1);
  endtask

  task automatic t_priority();
    clear_tab(); rule_cnt = 3;
    set_ent(2, 2'b10, 32'h0000_0000, 32'hFFFF_FFFF);
    set_ent(5, 2'b01, 32'h4000_0100, 32'h4000_01FF);
    lookup("R6 R7 wide entry first wins", 32'h4000_0150, 1'b1);
    clear_tab();
    set_ent(1, 2'b01, 32'h4000_0100, 32'h4000_01FF);
    set_ent(3, 2'b10, 32'h0000_0000, 32'hFFFF_FFFF);
    lookup("R6 R8 partial entry first wins", 32'h4000_0150, 1'b0);
  endtask

  task automatic t_edges();
    clear_tab(); rule_cnt = 1;
    set_ent(15, 2'b01, 32'h2000_1000, 32'h2000_1FFF);
    lookup("R7 exact page cover", 32'h2000_1ABC, 1'b1);
    set_ent(15, 2'b01, 32'h2000_0800, 32'h2000_1FFF);
    lookup("R7 start below page start", 32'h2000_1000, 1'b1);
    set_ent(15, 2'b01, 32'h2000_1001, 32'h2000_2FFF);
    lookup("R8 start inside page", 32'h2000_1000, 1'b0);
    set_ent(15, 2'b01, 32'h2000_0000, 32'h2000_1FFE);
    lookup("R8 end inside page", 32'h2000_1FFF, 1'b0);
    set_ent(15, 2'b01, 32'h2000_2000, 32'h2000_2FFF);
    lookup("R3 R9 adjacent page only", 32'h2000_1FFF, 1'b1);
  endtask

  task automatic t_gates();
    clear_tab();
    set_ent(0, 2'b01, 32'h8000_0008, 32'h8000_000F);
    rule_cnt = 1; prot_en = 1'b0;
    lookup("R4 protection off", 32'h8000_0000, 1'b1);
    prot_en = 1'b1; rule_cnt = 0;
    lookup("R4 zero rule count", 32'h8000_0000, 1'b1);
    clear_tab(); rule_cnt = 4;
    lookup("R9 count nonzero all off", 32'h8000_0000, 1'b1);
  endtask

  task automatic t_hold();
    clear_tab(); rule_cnt = 1;
    set_ent(0, 2'b01, 32'h8000_0008, 32'h8000_000F);
    lookup("R8 setup for hold", 32'h8000_0000, 1'b0);
    lk_addr = 32'h9000_0000;
    repeat (3) @(negedge clk);
    chk("R2 no pulse without strobe", res_valid, 1'b0);
    chk("R2 flag held", res_page, 1'b0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_nested();
    t_disabled();
    t_priority();
    t_edges();
    t_gates();
    t_hold();
    @(negedge clk); lk_valid = 1'b1; rst = 1'b1;
    @(negedge clk); lk_valid = 1'b0;
    chk("R1 reset over strobe", res_valid, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule